// File: doc/BRIEF.md
# Interrupt Request Deglitch Qualifier

This block sits between a storage device's interrupt request line and the host interrupt controller. The device signals that it needs service by holding its request line high. The wiring is noisy, and the downstream logic reacts to changes in either direction. Every change on the line is therefore treated as a candidate event that must be confirmed before anything is forwarded.

The raw line is first brought into the clock domain by a two-flop synchronizer. An edge tracker then spots any change of the synchronized level. The block waits in idle until it sees such a change. It then runs a bounded series of attempts. Each attempt captures the level on one cycle and compares it with the level on the next cycle. When the two captures match and the level is high, a single-cycle pulse goes to the interrupt controller. When they match and the level is low, or when every attempt fails to produce a match, the event is dropped and a saturating counter of spurious events goes up by one. Changes that happen while an evaluation runs do not start a new evaluation.

Top module: `irq_deglitch_qual`

## Requirements
- R1: While reset is active, and on the first cycles after it, `irq_pulse` is 0 and `spur_count` is 0.
- R2: With the default two synchronizer stages, a change of `irq_raw` to 1 that is then held makes `irq_pulse` read 1 after the fifth rising clock edge that follows the change, and 0 after the fourth.
- R3: `irq_pulse` is never high for two cycles in a row. Each confirmed event gives exactly one pulse.
- R4: A change to 0 that is then held is dropped. `spur_count` rises by one, and `irq_pulse` stays 0.
- R5: An attempt compares the synchronized level on two consecutive cycles. A failed attempt is followed at once by the next one, up to `MAX_TRIES` attempts (default 8). An event whose second attempt agrees on 1 produces a pulse.
- R6: If none of the `MAX_TRIES` attempts sees two matching captures, the event is dropped. `spur_count` rises by one, and there is no pulse, even if the line finishes high.
- R7: A pulse is produced only when two consecutive captures agree on level 1. This includes agreement on the very last permitted attempt.
- R8: A high glitch that has gone low again before the first capture is dropped and counted.
- R9: Changes of the line during an evaluation start no new evaluation. After an evaluation ends, a line that stays at its final level creates no further events.
- R10: `spur_count` goes up by exactly one per dropped event and stops at 2^`CNT_W`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_raw | input | 1 | Raw, unsynchronized level-high interrupt request |
| irq_pulse | output | 1 | One-cycle qualified interrupt toward the host controller |
| spur_count | output | CNT_W | Saturating count of dropped events |

## Verification
The bench drives toggle trains whose length is chosen so that either every one of the eight attempts sees disagreeing captures, or the final attempt just manages to agree on high. An off-by-one in the attempt limit would turn the first case into a pulse or the second into a drop. A short high glitch and a plain fall both have to be counted and never forwarded; a design that qualified on the edge instead of the settled level would forward them. The line is left high after an exhausted evaluation, to catch a design that re-arms on a stale edge and fires late. Repeated drops push the counter past its ceiling to catch wrap-around.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } eval_st_t;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_FIRE = 2'd1,
    VERDICT_DROP = 2'd2
  } verdict_t;

endpackage

// File: rtl/irq_rst_release.sv
module irq_rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign stage_d[i] = din;
      end else begin : g_body
        assign stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_track.sv
module irq_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic change
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  assign change = level ^ prev_q;

endmodule

// File: rtl/irq_eval_fsm.sv
module irq_eval_fsm
  import irq_qual_pkg::*;
#(
  parameter int MAX_TRIES = 8,
  localparam int TRY_W = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             change,
  output logic             fire_q,
  output logic             drop,
  output logic [TRY_W-1:0] attempt,
  output eval_st_t         state
);

  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);

  eval_st_t         state_q, state_d;
  logic [TRY_W-1:0] attempt_q, attempt_d;
  logic             first_q;
  logic             first_en;
  verdict_t         verdict;

  always_comb begin
    state_d   = state_q;
    attempt_d = attempt_q;
    first_en  = 1'b0;
    verdict   = VERDICT_NONE;
    unique case (state_q)
      ST_IDLE: begin
        if (change) begin
          state_d   = ST_FIRST;
          attempt_d = '0;
        end
      end
      ST_FIRST: begin
        first_en = 1'b1;
        state_d  = ST_SECOND;
      end
      ST_SECOND: begin
        if (level == first_q) begin
          state_d = ST_IDLE;
          verdict = level ? VERDICT_FIRE : VERDICT_DROP;
        end else if (attempt_q == LAST_TRY) begin
          state_d = ST_IDLE;
          verdict = VERDICT_DROP;
        end else begin
          attempt_d = attempt_q + TRY_W'(1);
          state_d   = ST_FIRST;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      attempt_q <= '0;
      fire_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      attempt_q <= attempt_d;
      fire_q    <= (verdict == VERDICT_FIRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
    end else if (first_en) begin
      first_q <= level;
    end
  end

  assign drop    = (verdict == VERDICT_DROP);
  assign attempt = attempt_q;
  assign state   = state_q;

endmodule

// File: rtl/irq_spur_counter.sv
module irq_spur_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/irq_deglitch_qual.sv
module irq_deglitch_qual
  import irq_qual_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_TRIES   = 8,
  parameter int CNT_W       = 8,
  localparam int TRY_W = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_raw,
  output logic             irq_pulse,
  output logic [CNT_W-1:0] spur_count
);

  logic             rst_sync_n;
  logic             level;
  logic             change;
  logic             drop;
  logic [TRY_W-1:0] attempt;
  eval_st_t         state;

  irq_rst_release #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (irq_raw),
    .dout  (level)
  );

  irq_edge_track u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .level  (level),
    .change (change)
  );

  irq_eval_fsm #(.MAX_TRIES(MAX_TRIES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level   (level),
    .change  (change),
    .fire_q  (irq_pulse),
    .drop    (drop),
    .attempt (attempt),
    .state   (state)
  );

  irq_spur_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (drop),
    .count (spur_count)
  );

endmodule

// File: rtl/irq_deglitch_qual_chk.sv
module irq_deglitch_qual_chk #(
  parameter int MAX_TRIES = 8,
  parameter int CNT_W     = 8,
  localparam int TRY_W = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pulse,
  input logic [CNT_W-1:0] spur_count,
  input logic             level,
  input logic [TRY_W-1:0] attempt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R3

  AST_PULSE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(level)); // R7

  AST_DROP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_count != $past(spur_count)) |-> !irq_pulse); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_count != $past(spur_count)) |-> (spur_count == CNT_W'($past(spur_count) + CNT_W'(1)))); // R10

  AST_COUNT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_count == CNT_MAX) |=> (spur_count == CNT_MAX)); // R10

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(attempt) < MAX_TRIES)); // R5

endmodule

bind irq_deglitch_qual irq_deglitch_qual_chk #(
  .MAX_TRIES (MAX_TRIES),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .irq_pulse  (irq_pulse),
  .spur_count (spur_count),
  .level      (level),
  .attempt    (attempt)
);

// File: tb/irq_deglitch_qual_tb.sv
module irq_deglitch_qual_tb;

  localparam int CW      = 4;
  localparam int CNT_TOP = (1 << CW) - 1;

  logic          clk;
  logic          rst_n;
  logic          irq_raw;
  logic          irq_pulse;
  logic [CW-1:0] spur_count;

  int checks;
  int fails;
  int model_cnt;
  bit mon_on;
  bit prev_pulse;
  logic [CW-1:0] last_cnt;

  int    exp_kind[$];
  int    exp_cnt[$];
  string exp_tag[$];

  irq_deglitch_qual #(.MAX_TRIES(8), .CNT_W(CW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_raw    (irq_raw),
    .irq_pulse  (irq_pulse),
    .spur_count (spur_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind 1 = qualified pulse, kind 0 = dropped event
  task automatic expect_evt(input int kind, input string tag);
    if (kind == 1) begin
      exp_kind.push_back(1);
      exp_cnt.push_back(model_cnt);
      exp_tag.push_back(tag);
    end else if (model_cnt < CNT_TOP) begin
      model_cnt++;
      exp_kind.push_back(0);
      exp_cnt.push_back(model_cnt);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      irq_raw = ~irq_raw;
    end
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (irq_pulse) begin
        check(!prev_pulse, "R3 pulse width", 2, 1);
        if (exp_kind.size() == 0) begin
          check(1'b0, "R9 unexpected pulse", 1, 0);
        end else begin
          check(exp_kind[0] == 1, exp_tag[0], 1, exp_kind[0]);
          void'(exp_kind.pop_front());
          void'(exp_cnt.pop_front());
          void'(exp_tag.pop_front());
        end
      end
      if (spur_count != last_cnt) begin
        if (exp_kind.size() == 0) begin
          check(1'b0, "R9 unexpected drop", int'(spur_count), int'(last_cnt));
        end else begin
          check(exp_kind[0] == 0 && int'(spur_count) == exp_cnt[0], exp_tag[0],
                int'(spur_count), exp_cnt[0]);
          void'(exp_kind.pop_front());
          void'(exp_cnt.pop_front());
          void'(exp_tag.pop_front());
        end
      end
      prev_pulse = irq_pulse;
      last_cnt   = spur_count;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; model_cnt = 0;
    mon_on = 1'b0; prev_pulse = 1'b0; last_cnt = '0;
    irq_raw = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 pulse in reset", int'(irq_pulse), 0);
    check(spur_count == '0, "R1 count in reset", int'(spur_count), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(irq_pulse == 1'b0, "R1 pulse after reset", int'(irq_pulse), 0);
    check(spur_count == '0, "R1 count after reset", int'(spur_count), 0);
    mon_on = 1'b1;

    // R2: clean rise, exact latency
    @(negedge clk);
    irq_raw = 1'b1;
    expect_evt(1, "R2 clean rise");
    repeat (4) @(negedge clk);
    check(irq_pulse == 1'b0, "R2 pulse too early", int'(irq_pulse), 0);
    @(negedge clk);
    check(irq_pulse == 1'b1, "R2 pulse at fifth edge", int'(irq_pulse), 1);
    settle();

    // R4: clean fall
    @(negedge clk);
    irq_raw = 1'b0;
    expect_evt(0, "R4 clean fall");
    settle();

    // R8: one-cycle high glitch
    toggles(2);
    expect_evt(0, "R8 short glitch");
    settle();

    // R6 and R9: every attempt disagrees, line ends high, no late pulse
    toggles(17);
    expect_evt(0, "R6 attempts exhausted");
    repeat (60) @(negedge clk);
    check(irq_raw == 1'b1 && exp_kind.size() == 0, "R9 no event after exhaustion",
          exp_kind.size(), 0);
    @(negedge clk);
    irq_raw = 1'b0;
    expect_evt(0, "R4 fall after exhaustion");
    settle();

    // R7: agreement on the last attempt
    toggles(15);
    expect_evt(1, "R7 last attempt agrees high");
    settle();
    @(negedge clk);
    irq_raw = 1'b0;
    expect_evt(0, "R4 fall after late agreement");
    settle();

    // R5: first attempt fails, second agrees high
    toggles(3);
    expect_evt(1, "R5 retry agrees");
    settle();
    @(negedge clk);
    irq_raw = 1'b0;
    expect_evt(0, "R4 fall after retry");
    settle();

    // R10: drive past saturation with glitches
    for (int k = 0; k < 14; k++) begin
      toggles(2);
      expect_evt(0, "R10 counting drops");
      repeat (12) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    check(int'(spur_count) == CNT_TOP, "R10 saturated value", int'(spur_count), CNT_TOP);

    // a clean pulse still works once saturated
    @(negedge clk);
    irq_raw = 1'b1;
    expect_evt(1, "R7 pulse while saturated");
    settle();
    check(int'(spur_count) == CNT_TOP, "R10 holds at top", int'(spur_count), CNT_TOP);

    check(exp_kind.size() == 0, "R3 all expected events seen", exp_kind.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule